// File: doc/BRIEF.md
# Three-Port Parallel I/O Group

This block provides 24 general-purpose I/O lines arranged as three 8-bit ports, named A, B and C, behind a small byte-wide register interface. It works in the way of a classic mode-0 parallel port controller. Each of ports A and B has one direction setting. Port C has two, one for its upper nibble and one for its lower nibble. A nibble set as output drives the value held in its output latch. A nibble set as input is left undriven, and its pins are read through a two-flop synchronizer.

The pad side is presented in tri-state style. `pin_out` carries the latch contents and `pin_oe` marks the lines that are being driven. A global I/O enable bit sits in its own register. While that bit is low, every line stays undriven, whatever the direction settings are. Software first sets the enable bit, then writes a control word to choose the directions, then loads the latches.

A port can be written while it is an input. The write only loads its latch, and the pins are not driven. When the port is later turned into an output, that latch value appears on the pins at once.

Top module: `pio_group`

## Requirements
- R1: After reset every nibble is an input, the enable bit is 0, every latch holds 0 and `pin_oe` is all zero. At that point a read of the control register at offset 0x0C returns 0x9B, and a read of the enable register at offset 0x10 returns 0x00.
- R2: Bit 0 of the enable register at offset 0x10 is the global I/O enable. While it is 0, `pin_oe` is all zero, whatever the direction settings are.
- R3: A write to offset 0x0C with bit 7 set loads the directions, where 1 means input and 0 means output. Bit 4 sets port A, bit 1 sets port B, bit 3 sets the upper nibble of port C and bit 0 sets its lower nibble. A read of the register returns 0x80 with those four bits in the same positions, so writing 0x80 makes every nibble an output.
- R4: A write to offset 0x0C with bit 7 clear is ignored, and the directions are left unchanged.
- R5: A write to offset 0x00, 0x04 or 0x08 loads the latch of port A, B or C, whatever the port's direction. `pin_out[7:0]`, `pin_out[15:8]` and `pin_out[23:16]` always carry the latches of A, B and C.
- R6: Each bit of `pin_oe` is 1 exactly when the enable bit is 1 and the nibble holding that line is set as output.
- R7: A read of a port returns the latch value for every nibble that is set as output.
- R8: A read of a port returns the synchronized pin value for every nibble that is set as input. A change on `pin_in` made between two rising edges does not show on a read taken after the first following rising edge. It does show on a read taken after the second.
- R9: When a nibble changes from input to output, it drives its existing latch value from the first cycle after the control write, with no intermediate zero.
- R10: A read of any offset other than 0x00, 0x04, 0x08, 0x0C or 0x10 returns 0. A write to any such offset changes no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the register being accessed |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 24 | External line levels (C, B, A from high to low) |
| pin_out | output | 24 | Latch values presented to the pads |
| pin_oe | output | 24 | Per-line drive enable |

## Verification
The assertions assume that `bus_wr` and `bus_addr` are stable around each rising edge and that `pin_in` may change at any time. They also assume that a write strobe lasts exactly one cycle per access. The stimulus meets these assumptions by changing every input at the falling edge and by lowering `bus_wr` at the next falling edge. It reads only at falling edges that the design has already settled on. In the synchronizer test, the pin change is placed between edges, so that the one-edge and two-edge cases can be told apart.

// File: rtl/pio_pkg.sv
// Package: shared constants and types for the parallel I/O group.
// Assumes byte offsets on the register bus and one direction bit per nibble class.
package pio_pkg;
    localparam int PIO_NUM_PORTS   = 3;
    localparam int PIO_PORT_STRIDE = 4;
    localparam int PIO_CTRL_OFFS   = 12;
    localparam int PIO_EN_OFFS     = 16;

    // Direction per nibble class, 1 = input, 0 = output
    typedef struct packed {
        logic a;
        logic b;
        logic c_hi;
        logic c_lo;
    } pio_dir_t;
endpackage

// File: rtl/pio_sync2.sv
// Module: two-flop synchronizer for asynchronous pin levels.
// Assumes the inputs are single-bit independent levels; no bus coherency is implied.
module pio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Two resettable capture stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/pio_ctrl_regs.sv
// Module: direction control word and global I/O enable registers.
// Assumes DW >= 8; a control write without bit 7 is discarded (no bit set/reset).
module pio_ctrl_regs
    import pio_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output pio_dir_t      dir_o,
    output logic          io_en_o,
    output logic [DW-1:0] ctrl_rd_o,
    output logic [DW-1:0] en_rd_o
);
    localparam logic [AW-1:0] CTRL_A = AW'(PIO_CTRL_OFFS);
    localparam logic [AW-1:0] EN_A   = AW'(PIO_EN_OFFS);

    pio_dir_t dir_q;
    logic     en_q;
    logic     ctrl_hit;
    logic     en_hit;
    logic     bits_unused;

    assign ctrl_hit    = bus_wr && (bus_addr == CTRL_A);
    assign en_hit      = bus_wr && (bus_addr == EN_A);
    assign bits_unused = ^bus_wdata;

    // Direction register: loaded only by a mode-set word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '{a: 1'b1, b: 1'b1, c_hi: 1'b1, c_lo: 1'b1};
        end else if (ctrl_hit && bus_wdata[7]) begin
            dir_q <= '{a: bus_wdata[4], b: bus_wdata[1],
                       c_hi: bus_wdata[3], c_lo: bus_wdata[0]};
        end
    end

    // Global enable register
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= 1'b0;
        else if (en_hit) en_q <= bus_wdata[0];
    end

    assign dir_o     = dir_q;
    assign io_en_o   = en_q;
    assign ctrl_rd_o = DW'({1'b1, 2'b00, dir_q.a, dir_q.c_hi, 1'b0, dir_q.b, dir_q.c_lo});
    assign en_rd_o   = DW'(en_q);

    // R4: a control word lacking bit 7 leaves directions untouched
    p_ctrl_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && !bus_wdata[7]) |=> $stable(dir_o));
endmodule

// File: rtl/pio_port_slice.sv
// Module: one 8-bit port with output latch, nibble directions, pad enables and read path.
// Assumes PW is even; the latch loads on every write to OFFS, whatever the direction.
module pio_port_slice #(
    parameter int            PW   = 8,
    parameter int            AW   = 5,
    parameter logic [AW-1:0] OFFS = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [PW-1:0] bus_wdata,
    input  logic          io_en,
    input  logic          dir_hi,
    input  logic          dir_lo,
    input  logic [PW-1:0] pin_in,
    output logic [PW-1:0] pin_out,
    output logic [PW-1:0] pin_oe,
    output logic [PW-1:0] rd_val
);
    localparam int NIB = PW / 2;

    logic [PW-1:0] latch_q;
    logic [PW-1:0] pin_sync;
    logic          wr_hit;

    assign wr_hit = bus_wr && (bus_addr == OFFS);

    // Output latch, loaded regardless of direction
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_q <= '0;
        else if (wr_hit) latch_q <= bus_wdata;
    end

    pio_sync2 #(.W(PW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_in),
        .q_o   (pin_sync)
    );

    // Pad drive and per-nibble read selection
    always_comb begin
        pin_out = latch_q;
        pin_oe  = {{NIB{io_en & ~dir_hi}}, {NIB{io_en & ~dir_lo}}};
        rd_val  = {dir_hi ? pin_sync[PW-1:NIB] : latch_q[PW-1:NIB],
                   dir_lo ? pin_sync[NIB-1:0]  : latch_q[NIB-1:0]};
    end

    // R5: a write to this port's offset lands in the latch
    p_latch_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (pin_out == $past(bus_wdata)));

    // R10: with no write to this offset the latch holds
    p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(pin_out));
endmodule

// File: rtl/pio_group.sv
// Module: top of the three-port parallel I/O group with register read mux.
// Assumes byte offsets: ports at multiples of the stride, then control and enable.
module pio_group
    import pio_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic                              bus_wr,
    input  logic [PORT_W-1:0]                 bus_wdata,
    output logic [PORT_W-1:0]                 bus_rdata,
    input  logic [PIO_NUM_PORTS*PORT_W-1:0]   pin_in,
    output logic [PIO_NUM_PORTS*PORT_W-1:0]   pin_out,
    output logic [PIO_NUM_PORTS*PORT_W-1:0]   pin_oe
);
    localparam int            NP     = PIO_NUM_PORTS;
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(PIO_CTRL_OFFS);
    localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(PIO_EN_OFFS);

    pio_dir_t          dir;
    logic              io_en;
    logic [PORT_W-1:0] ctrl_rd;
    logic [PORT_W-1:0] en_rd;
    logic [NP-1:0]     dir_hi;
    logic [NP-1:0]     dir_lo;
    logic [PORT_W-1:0] port_rd [NP];

    pio_ctrl_regs #(.DW(PORT_W), .AW(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .dir_o     (dir),
        .io_en_o   (io_en),
        .ctrl_rd_o (ctrl_rd),
        .en_rd_o   (en_rd)
    );

    // Map the direction classes onto each port's nibbles
    always_comb begin
        dir_hi = {dir.c_hi, dir.b, dir.a};
        dir_lo = {dir.c_lo, dir.b, dir.a};
    end

    for (genvar g = 0; g < NP; g++) begin : g_port
        pio_port_slice #(
            .PW   (PORT_W),
            .AW   (ADDR_W),
            .OFFS (ADDR_W'(g * PIO_PORT_STRIDE))
        ) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .bus_wr    (bus_wr),
            .bus_addr  (bus_addr),
            .bus_wdata (bus_wdata),
            .io_en     (io_en),
            .dir_hi    (dir_hi[g]),
            .dir_lo    (dir_lo[g]),
            .pin_in    (pin_in[g*PORT_W +: PORT_W]),
            .pin_out   (pin_out[g*PORT_W +: PORT_W]),
            .pin_oe    (pin_oe[g*PORT_W +: PORT_W]),
            .rd_val    (port_rd[g])
        );
    end

    // Register read mux; unmapped offsets return zero
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NP; i++) begin
            if (bus_addr == ADDR_W'(i * PIO_PORT_STRIDE)) bus_rdata = port_rd[i];
        end
        if (bus_addr == CTRL_A) bus_rdata = ctrl_rd;
        if (bus_addr == EN_A)   bus_rdata = en_rd;
    end

    // R1: reset leaves every line undriven
    p_reset_hiz_r1: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0));

    // R2: with the enable register clear nothing drives
    p_enable_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !io_en |-> (pin_oe == '0));

    // R6: port A drive follows enable and its direction class
    p_port_a_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_en && !dir.a) |-> (pin_oe[PORT_W-1:0] == '1));
endmodule

// File: tb/sim_pio_group.sv
module sim_pio_group;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [23:0] pin_in;
    logic [23:0] pin_out;
    logic [23:0] pin_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pio_group u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 oe", pin_oe, 24'h0);
        check("R1 out", pin_out, 24'h0);
        bus_read(5'h0C, d); check("R1 ctrl", d, 8'h9B);
        bus_read(5'h10, d); check("R1 en", d, 8'h00);
    endtask

    task automatic t_enable_gate;
        logic [7:0] d;
        bus_write(5'h0C, 8'h80);
        check("R2 oe with enable low", pin_oe, 24'h0);
        bus_write(5'h10, 8'h01);
        bus_read(5'h10, d); check("R2 en readback", d, 8'h01);
        check("R6 all out", pin_oe, 24'hFFFFFF);
        bus_write(5'h10, 8'h00);
        check("R2 disable", pin_oe, 24'h0);
        bus_write(5'h10, 8'h01);
    endtask

    task automatic t_ctrl_decode;
        logic [7:0] d;
        bus_write(5'h0C, 8'h90);
        check("R3 A input", pin_oe, 24'hFFFF00);
        bus_read(5'h0C, d); check("R3 readback", d, 8'h90);
        bus_write(5'h0C, 8'h82);
        check("R3 B input", pin_oe, 24'hFF00FF);
        bus_write(5'h0C, 8'h88);
        check("R6 C upper input", pin_oe, 24'h0FFFFF);
        bus_write(5'h0C, 8'h81);
        check("R6 C lower input", pin_oe, 24'hF0FFFF);
        bus_write(5'h0C, 8'h89);
        check("R3 C input", pin_oe, 24'h00FFFF);
    endtask

    task automatic t_ignore;
        logic [7:0] d;
        bus_write(5'h0C, 8'h80);
        bus_write(5'h0C, 8'h1B);
        check("R4 oe kept", pin_oe, 24'hFFFFFF);
        bus_read(5'h0C, d); check("R4 ctrl kept", d, 8'h80);
    endtask

    task automatic t_latch;
        logic [7:0] d;
        pin_in = 24'h123456;
        bus_write(5'h0C, 8'h9B);
        bus_write(5'h00, 8'h5A);
        bus_write(5'h04, 8'hC3);
        bus_write(5'h08, 8'h7E);
        check("R5 latches on pins", pin_out, 24'h7EC35A);
        check("R5 inputs undriven", pin_oe, 24'h0);
        bus_read(5'h00, d); check("R8 A reads pins", d, 8'h56);
        bus_read(5'h04, d); check("R8 B reads pins", d, 8'h34);
        bus_write(5'h0C, 8'h80);
        check("R9 oe on switch", pin_oe, 24'hFFFFFF);
        check("R9 value on switch", pin_out, 24'h7EC35A);
        bus_read(5'h00, d); check("R7 A latch", d, 8'h5A);
        bus_read(5'h04, d); check("R7 B latch", d, 8'h C3);
        bus_write(5'h0C, 8'h81);
        bus_read(5'h08, d); check("R7 R8 C mixed", d, 8'h72);
    endtask

    task automatic t_sync;
        bus_write(5'h0C, 8'h9B);
        @(negedge clk);
        bus_addr = 5'h00;
        pin_in = 24'h1234A5;
        @(posedge clk);
        @(negedge clk);
        #1 check("R8 one edge old", bus_rdata, 8'h56);
        @(posedge clk);
        @(negedge clk);
        #1 check("R8 two edges new", bus_rdata, 8'hA5);
    endtask

    task automatic t_unmapped;
        logic [7:0] d;
        bus_write(5'h0C, 8'h80);
        bus_write(5'h01, 8'hFF);
        bus_write(5'h14, 8'hFF);
        check("R10 latches kept", pin_out, 24'h7EC35A);
        bus_read(5'h14, d); check("R10 read 0x14", d, 8'h00);
        bus_read(5'h01, d); check("R10 read 0x01", d, 8'h00);
        bus_read(5'h00, d); check("R10 A intact", d, 8'h5A);
    endtask

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; pin_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_gate();
        t_ctrl_decode();
        t_ignore();
        t_latch();
        t_sync();
        t_unmapped();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #20000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule